// File: doc/BRIEF.md
# I2C Serial EEPROM Target (256 x 8)

This block is a synthesizable I2C target that behaves like a 256-byte serial EEPROM. It runs on a fast system clock and oversamples the SCL and SDA pins through short synchronizer chains. It finds Start and Stop conditions and samples data on SCL rising edges. It pulls SDA low through an open-drain output enable whenever it acknowledges a byte or sends a zero bit.

A write names the word address and then streams data bytes. These go into a 16-entry page buffer. On Stop the buffer is copied into the array and a programming period of `BUSY_CYCLES` system clocks begins. During that period the target ignores every transfer, including its own address. A read streams bytes from an internal pointer until the master declines a byte. The pointer can first be set by a dummy write followed by a repeated Start, or the read can carry on from wherever the previous access left the pointer.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_oe` is low and every array byte reads back as 0xFF.
- R2: The address byte is decoded as follows: bits 7:4 must be 1010, bits 3:1 must equal `cs_strap`, and bit 0 selects read (1) or write (0). Only a matching byte is acknowledged, by pulling SDA low for the ninth pulse. On a mismatch the target stays silent until the next Start.
- R3: In a write, the word address byte and every data byte are acknowledged.
- R4: The word address loads the pointer. Each data byte lands at the pointer. The pointer's low four bits then advance and wrap inside the 16-byte page, while its upper four bits stay fixed. The array changes only at Stop.
- R5: When a write carries more than 16 data bytes, only the last 16 are kept. Each extra byte replaces the oldest byte in the page buffer.
- R6: A Stop that commits at least one byte starts a busy period of `BUSY_CYCLES` clocks, in which no byte is acknowledged. A Stop after a write with no data bytes starts no busy period.
- R7: A read sends the byte at the pointer MSB first and increments the pointer after every byte, wrapping from 255 to 0. A read with no word address starts at the pointer left by the previous access.
- R8: After the master leaves SDA high on the acknowledge of a read byte, the target releases SDA and sends nothing more until the next Start or Stop.
- R9: A Start that arrives without a preceding Stop restarts address reception and discards any data bytes not yet committed.
- R10: `sda_oe` changes only while SCL is low, so an acknowledge or data bit is held steady across the whole SCL high period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock pin level |
| sda_i | input | 1 | Serial data pin level |
| cs_strap | input | 3 | Chip-select strap compared with address bits 3:1 |
| sda_oe | output | 1 | When high, pulls SDA low |

## Verification
A wrong pointer shows up on the first byte read back after the faulty access: a wrap that escapes its page puts data into a neighbouring page, which then reads 0xFF where a value was expected. A wrong busy count shows up as an acknowledge on the very next address byte, or as a missing one after the period should have ended. A bit-counter slip turns into a shifted data byte or a misplaced acknowledge within the same byte frame. A stale drive across a Start or Stop makes SDA change while SCL is high, and the SCL-phase check flags that on the clock where it happens.

// File: rtl/i2c_eeprom_pkg.sv
// Package: shared state encoding and address constants for the EEPROM target.
package i2c_eeprom_pkg;
    // Protocol states of the byte-level controller
    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for Start
        ST_DEV,     // receiving device address byte
        ST_WADDR,   // receiving word address byte
        ST_WDATA,   // receiving write data bytes
        ST_RDATA,   // transmitting read data bytes
        ST_IGNORE   // not addressed or declined; wait for Start/Stop
    } fsm_t;

    localparam int          CS_W      = 3;
    localparam logic [3:0]  CTRL_CODE = 4'b1010;
endpackage

// File: rtl/i2c_bus_cond.sv
// Module: i2c_bus_cond
// Synchronizes SCL and SDA into the system clock domain and flags SCL edges
// and Start/Stop conditions. Assumes the system clock is many times faster
// than SCL, so each bus level is seen for several clocks.
module i2c_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] scl_pipe;
    logic [PIPE_W-1:0] sda_pipe;

    // Shift both pins through synchronizer plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PIPE_W-2:0], scl_i};
            sda_pipe <= {sda_pipe[PIPE_W-2:0], sda_i};
        end
    end

    logic scl_cur, scl_prev, sda_cur, sda_prev;
    assign scl_cur  = scl_pipe[PIPE_W-2];
    assign scl_prev = scl_pipe[PIPE_W-1];
    assign sda_cur  = sda_pipe[PIPE_W-2];
    assign sda_prev = sda_pipe[PIPE_W-1];

    // Edge and bus-condition decode from current and previous sample
    assign sda_lvl   = sda_cur;
    assign scl_rise  = scl_cur & ~scl_prev;
    assign scl_fall  = ~scl_cur & scl_prev;
    assign start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
    assign stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/eeprom_store.sv
// Module: eeprom_store
// Byte array with a page buffer. Buffered writes land by their low address
// bits, so overflow replaces the oldest slot. Commit copies every valid slot
// into the array in one clock and starts the busy countdown.
// Assumes buf_we, buf_clr and commit are never asserted together.
module eeprom_store #(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_clr,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              commit,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int PAGE_SZ = 1 << PAGE_W;
    localparam int HI_W    = ADDR_W - PAGE_W;
    localparam int BCW     = $clog2(BUSY_CYCLES + 1);

    logic [DATA_W-1:0]  mem  [DEPTH];
    logic [DATA_W-1:0]  pbuf [PAGE_SZ];
    logic [PAGE_SZ-1:0] pvalid;
    logic [HI_W-1:0]    page_q;
    logic [BCW-1:0]     busy_cnt;
    logic               do_commit;

    assign do_commit = commit && (pvalid != '0);

    // Page buffer: store by in-page offset, track which slots hold data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pvalid <= '0;
            page_q <= '0;
            for (int i = 0; i < PAGE_SZ; i++) pbuf[i] <= '0;
        end else if (buf_clr || commit) begin
            pvalid <= '0;
        end else if (buf_we) begin
            pbuf[buf_addr[PAGE_W-1:0]]   <= buf_data;
            pvalid[buf_addr[PAGE_W-1:0]] <= 1'b1;
            page_q                       <= buf_addr[ADDR_W-1:PAGE_W];
        end
    end

    // Array: erased on reset, whole page written in parallel on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (do_commit) begin
            for (int i = 0; i < PAGE_SZ; i++)
                if (pvalid[i]) mem[{page_q, PAGE_W'(i)}] <= pbuf[i];
        end
    end

    // Programming period countdown
    always_ff @(posedge clk) begin
        if (!rst_n)         busy_cnt <= '0;
        else if (do_commit) busy_cnt <= BCW'(BUSY_CYCLES);
        else if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
    end

    assign busy    = (busy_cnt != '0);
    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_eeprom_target.sv
// Module: i2c_eeprom_target
// I2C target modelling a 256 x 8 serial EEPROM. Decodes the address byte,
// word address, write data and read data; drives SDA only through sda_oe.
// Assumes an external pull-up on SDA and an SCL low phase longer than the
// synchronizer latency.
module i2c_eeprom_target
    import i2c_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [CS_W-1:0] cs_strap,
    output logic            sda_oe
);
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

    logic              sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              busy, buf_we, commit, dev_match, byte_end;
    logic [DATA_W-1:0] rd_data;
    fsm_t              state;
    logic [CNT_W-1:0]  bit_cnt;
    logic              ack_ph, m_nack;
    logic [DATA_W-1:0] sh;
    logic [ADDR_W-1:0] ptr;

    i2c_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    eeprom_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W),
        .BUSY_CYCLES(BUSY_CYCLES)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .buf_clr(start_det), .buf_we(buf_we),
        .buf_addr(ptr), .buf_data(sh), .commit(commit), .rd_addr(ptr),
        .rd_data(rd_data), .busy(busy)
    );

    // Byte boundary: SCL falls after the eighth bit of a byte
    assign byte_end  = scl_fall && !ack_ph && (bit_cnt == LAST_BIT)
                       && !start_det && !stop_det;
    assign dev_match = (sh[7:4] == CTRL_CODE) && (sh[3:1] == cs_strap) && !busy;
    assign buf_we    = byte_end && (state == ST_WDATA);
    assign commit    = stop_det && (state == ST_WDATA);

    // Protocol sequencer: bit counting, acknowledge and transmit drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            m_nack  <= 1'b0;
            sh      <= '0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
        end else if (start_det) begin
            state   <= ST_DEV;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            ack_ph  <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (state != ST_IDLE && state != ST_IGNORE) begin
            if (scl_rise) begin
                if (ack_ph) begin
                    m_nack <= sda_lvl;
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (state != ST_RDATA) sh <= {sh[DATA_W-2:0], sda_lvl};
                end
            end
            if (scl_fall) begin
                if (ack_ph) begin
                    ack_ph  <= 1'b0;
                    bit_cnt <= '0;
                    sda_oe  <= 1'b0;
                    if (state == ST_RDATA) begin
                        if (m_nack) begin
                            state <= ST_IGNORE;
                        end else begin
                            sh     <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                        end
                    end
                end else if (bit_cnt == LAST_BIT) begin
                    ack_ph <= 1'b1;
                    unique case (state)
                        ST_DEV: begin
                            if (dev_match) begin
                                sda_oe <= 1'b1;
                                state  <= sh[0] ? ST_RDATA : ST_WADDR;
                            end else begin
                                state  <= ST_IGNORE;
                            end
                        end
                        ST_WADDR: begin
                            sda_oe <= 1'b1;
                            ptr    <= ADDR_W'(sh);
                            state  <= ST_WDATA;
                        end
                        ST_WDATA: begin
                            sda_oe <= 1'b1;
                            ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                        end
                        ST_RDATA: begin
                            sda_oe <= 1'b0;
                            ptr    <= ptr + 1'b1;
                        end
                        default: state <= ST_IGNORE;
                    endcase
                end else if (state == ST_RDATA && bit_cnt != '0) begin
                    sh     <= {sh[DATA_W-2:0], 1'b0};
                    sda_oe <= ~sh[DATA_W-2];
                end
            end
        end
    end
endmodule

// File: rtl/i2c_eeprom_chk.sv
// Module: i2c_eeprom_chk
// Protocol checker bound into i2c_eeprom_target. Watches the SDA drive
// against SCL, the busy period and the Start handling.
module i2c_eeprom_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe,
    input logic             busy,
    input logic             start_det,
    input logic             stop_det,
    input logic [CNT_W-1:0] bit_cnt
);
    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);

    // R6
    busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !busy);

    // R4
    commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_det));

    // R9
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_oe && bit_cnt == '0));
endmodule

bind i2c_eeprom_target i2c_eeprom_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .busy(busy),
    .start_det(start_det), .stop_det(stop_det), .bit_cnt(bit_cnt)
);

// File: tb/i2c_eeprom_target_bench.sv
// Bench: i2c_eeprom_target_bench
// Directed scenarios acting as an I2C master; each task checks its results.
module i2c_eeprom_target_bench;
    localparam int        BUSY = 1500;
    localparam int        Q    = 8;
    localparam logic [2:0] CS  = 3'b101;
    localparam int        WD   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;
    int   n_cmp = 0;
    int   n_bad = 0;
    logic [7:0] wbuf [32];
    logic [7:0] rbuf [32];

    assign sda_bus = sda_m & ~sda_oe;

    always #10 clk = ~clk;

    i2c_eeprom_target #(.BUSY_CYCLES(BUSY)) u_i2c_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
        .cs_strap(CS), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
    endtask

    // Sends a byte; ack is the level seen early in the ninth high phase,
    // held tells whether it stayed the same until just before SCL fell
    task automatic send_byte(input logic [7:0] b, output logic ack, output logic held);
        logic s1, s2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2);
        s1 = sda_bus; wq(2*Q - 3);
        s2 = sda_bus; wq(1);
        scl_m = 1'b0; wq(Q);
        ack  = ~s1;
        held = (s1 == s2);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
        end
        sda_m = ~mack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1010, CS, rw};
    endfunction

    task automatic do_write(input logic [7:0] addr, input int n, input string req);
        logic a, h;
        bus_start();
        send_byte(dev(1'b0), a, h); chk({req, " R2 dev ack"}, {7'd0, a}, 8'd1);
        send_byte(addr, a, h);      chk({req, " R3 waddr ack"}, {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a, h); chk({req, " R3 data ack"}, {7'd0, a}, 8'd1);
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] addr, input int n);
        logic a, h;
        bus_start();
        send_byte(dev(1'b0), a, h);
        send_byte(addr, a, h);
        bus_start();
        send_byte(dev(1'b1), a, h); chk("R9 read-after-restart ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) recv_byte(k != n - 1, rbuf[k]);
        bus_stop();
    endtask

    task automatic wait_busy();
        wq(BUSY + 50);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe after reset", {7'd0, sda_oe}, 8'd0);
        do_read(8'h10, 2);
        chk("R1 erased byte 0x10", rbuf[0], 8'hFF);
        chk("R1 erased byte 0x11", rbuf[1], 8'hFF);
    endtask

    task automatic t_addr_match();
        logic a, h;
        bus_start();
        send_byte({4'b1010, 3'b100, 1'b0}, a, h);
        chk("R2 wrong strap no ack", {7'd0, a}, 8'd0);
        send_byte(8'h00, a, h);
        chk("R2 silent after mismatch", {7'd0, a}, 8'd0);
        bus_stop();
        bus_start();
        send_byte({4'b1011, CS, 1'b0}, a, h);
        chk("R2 wrong code no ack", {7'd0, a}, 8'd0);
        bus_stop();
    endtask

    task automatic t_basic_write();
        logic a, h;
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        bus_start();
        send_byte(dev(1'b0), a, h);
        chk("R10 address ack held over high", {7'd0, h}, 8'd1);
        send_byte(8'h25, a, h);
        for (int k = 0; k < 3; k++) send_byte(wbuf[k], a, h);
        chk("R3 last data ack", {7'd0, a}, 8'd1);
        bus_stop();
        wait_busy();
        do_read(8'h25, 3);
        chk("R4 byte 0x25", rbuf[0], 8'hA1);
        chk("R4 byte 0x26", rbuf[1], 8'hB2);
        chk("R7 byte 0x27", rbuf[2], 8'hC3);
    endtask

    task automatic t_busy();
        logic a, h;
        wbuf[0] = 8'h77;
        do_write(8'h60, 1, "busy");
        bus_start();
        send_byte(dev(1'b0), a, h);
        chk("R6 no ack while busy", {7'd0, a}, 8'd0);
        bus_stop();
        wait_busy();
        bus_start();
        send_byte(dev(1'b0), a, h);
        chk("R6 ack after busy", {7'd0, a}, 8'd1);
        send_byte(8'h10, a, h);
        bus_stop();
        bus_start();
        send_byte(dev(1'b0), a, h);
        chk("R6 empty write starts no busy", {7'd0, a}, 8'd1);
        bus_stop();
    endtask

    task automatic t_page_wrap();
        for (int k = 0; k < 4; k++) wbuf[k] = 8'(k + 1);
        do_write(8'h3E, 4, "wrap");
        wait_busy();
        do_read(8'h3E, 3);
        chk("R4 byte 0x3E", rbuf[0], 8'h01);
        chk("R4 byte 0x3F", rbuf[1], 8'h02);
        chk("R4 next page untouched 0x40", rbuf[2], 8'hFF);
        do_read(8'h30, 2);
        chk("R4 wrapped 0x30", rbuf[0], 8'h03);
        chk("R4 wrapped 0x31", rbuf[1], 8'h04);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 18; k++) wbuf[k] = 8'(8'h80 + k);
        do_write(8'h50, 18, "overflow");
        wait_busy();
        do_read(8'h50, 3);
        chk("R5 slot 0x50 overwritten", rbuf[0], 8'h90);
        chk("R5 slot 0x51 overwritten", rbuf[1], 8'h91);
        chk("R5 slot 0x52 kept", rbuf[2], 8'h82);
        do_read(8'h5F, 1);
        chk("R5 slot 0x5F kept", rbuf[0], 8'h8F);
    endtask

    task automatic t_read_wrap();
        logic a, h;
        logic [7:0] b;
        wbuf[0] = 8'h11; wbuf[1] = 8'h33;
        do_write(8'h00, 2, "low");
        wait_busy();
        wbuf[0] = 8'h22;
        do_write(8'hFF, 1, "high");
        wait_busy();
        do_read(8'hFF, 2);
        chk("R7 byte 0xFF", rbuf[0], 8'h22);
        chk("R7 wrap to 0x00", rbuf[1], 8'h11);
        bus_start();
        send_byte(dev(1'b1), a, h);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R7 current-address read 0x01", b, 8'h33);
    endtask

    task automatic t_nack_release();
        logic a, h;
        logic [7:0] b;
        bus_start();
        send_byte(dev(1'b0), a, h);
        send_byte(8'h25, a, h);
        bus_start();
        send_byte(dev(1'b1), a, h);
        recv_byte(1'b0, b);
        chk("R8 byte before nack", b, 8'hA1);
        recv_byte(1'b0, b);
        chk("R8 SDA released after nack", b, 8'hFF);
        bus_stop();
    endtask

    task automatic t_restart_discard();
        logic a, h;
        logic [7:0] b;
        bus_start();
        send_byte(dev(1'b0), a, h);
        send_byte(8'h25, a, h);
        send_byte(8'hEE, a, h);
        bus_start();
        send_byte(dev(1'b1), a, h);
        chk("R9 address ack after restart", {7'd0, a}, 8'd1);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R9 read continues at 0x26", b, 8'hB2);
        do_read(8'h25, 1);
        chk("R9 discarded byte not stored", rbuf[0], 8'hA1);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=finished", WD);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wq(5);
        rst_n = 1'b1;
        wq(5);
        t_reset();
        t_addr_match();
        t_basic_write();
        t_busy();
        t_page_wrap();
        t_overflow();
        t_read_wrap();
        t_nack_release();
        t_restart_discard();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule